// File: doc/BRIEF.md
# Pausable Serial Register Port

This block is a slave serial port that gives an external host access to a bank of byte-wide registers. The host supplies the serial clock and an active-low chip select. Both signals are brought into the system clock domain through a synchronizer chain, and all port state advances on edges of the synchronized serial clock. Each transfer starts with one instruction byte. That byte selects the direction, a byte count from 1 to 4, and a start address. The data bytes follow, and the address steps up by one after each byte.

Chip select acts as a pause and does not abort a transfer. While it is high, the bit counter, byte counter, address and shift registers all hold their values, and serial clock edges are discarded. When it goes low again, the transfer continues from the exact bit where it stopped. The host must put the serial clock back at the level it had when the pause began. The output enables follow the raw chip select pin through combinational logic only, so the data lines release in the same cycle that chip select rises.

Write data always arrives on the shared line. A configuration input chooses where read data leaves: on the dedicated output line, or on the shared line. In this design a tri-state pin is modelled as a value and an enable. The system clock is expected to run at least eight times faster than the serial clock.

Top module: `serial_pause_slave`

## Requirements
- R1: The port samples its input on each rising serial clock edge, most significant bit first. The first byte of a transfer is the instruction: bit 7 is 1 for a read and 0 for a write, bits 6:5 hold the byte count minus one, and bits 4:0 hold the start address.
- R2: In a write, each received data byte produces exactly one single-cycle `reg_we` pulse. During that pulse, `reg_addr` and `reg_wdata` carry the target address and the byte. The address then steps by one, wrapping from 31 to 0.
- R3: In a read, the port shifts out the bytes from `reg_rdata` at successive addresses, most significant bit first. The first bit is valid before the first rising edge of the byte. Each later bit changes after a falling edge. The address wraps from 31 to 0.
- R4: Once the port has moved the number of data bytes the instruction asked for, it treats the next byte as a new instruction.
- R5: While `cs_n` is high, the port ignores serial clock edges and keeps its position in the transfer, whether it stopped mid-byte or at a byte boundary. After `cs_n` falls, the transfer continues from that position and no register write occurs during the pause.
- R6: Both output enables are low in any cycle in which `cs_n` is high. This includes the cycle in which `cs_n` rises during a read.
- R7: When `bidir_mode` is 1, read data drives `sdio_o` with `sdio_oe` high and `sdo_oe` stays low. When `bidir_mode` is 0, read data drives `sdo_o` with `sdo_oe` high and `sdio_oe` stays low.
- R8: Neither output enable is high during an instruction byte or during a write transfer.
- R9: After reset, both output enables and `reg_we` are low and the port waits for an instruction.
- R10: With `cs_n` held low, the port accepts back-to-back transfers with no gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| bidir_mode | input | 1 | 1 sends read data on the shared line |
| sdio_i | input | 1 | Value received on the shared data line |
| sdio_o | output | 1 | Value driven onto the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_o | output | 1 | Value on the dedicated output line |
| sdo_oe | output | 1 | Drive enable for the dedicated output line |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write strobe, one cycle long |
| reg_rdata | input | 8 | Register read data at `reg_addr` |

## Verification
The hardest case to reach is a pause that falls in the middle of a byte while the host keeps toggling the serial clock. Correct behaviour then depends on the frozen bit count and on the edge detector seeing no false edge when the port resumes. The directed tests stop a read after three bits and a write both at a byte boundary and after four bits. During each pause they send several full clock pulses and then return the clock to its earlier level. They check that the bytes read or written are exactly the bytes an uninterrupted transfer would give, and that the number of register writes is correct. The enable-release case is reached by raising chip select between two read bits and sampling the enables one time step later, before any clock edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CW = $clog2(BYTE_W);

   typedef enum logic {
      PH_INSN = 1'b0,
      PH_DATA = 1'b1
   } ssp_phase_e;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int             W      = 2,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   RST_V  = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $fatal(1, "ssp_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= RST_V;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
   import ssp_pkg::*;
#(
   parameter int LEN_W  = 2,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_act,
   input  logic              sdi,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              drive,
   output logic              tx_bit,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte
);
   localparam int LEN_HI = BYTE_W - 2;

   ssp_phase_e         phase_q;
   logic               sclk_d;
   logic [BIT_CW-1:0]  bit_cnt;
   logic [BYTE_W-1:0]  rx_q;
   logic [BYTE_W-1:0]  tx_q;
   logic [LEN_W-1:0]   left_q;
   logic               rd_q;
   logic               adv_q;
   logic               load_q;
   logic               rise;
   logic               fall;
   logic               last_bit;
   logic [BYTE_W-1:0]  full_byte;

   assign rise      = cs_act &  sclk_s & ~sclk_d;
   assign fall      = cs_act & ~sclk_s &  sclk_d;
   assign last_bit  = (bit_cnt == BIT_CW'(BYTE_W - 1));
   assign full_byte = {rx_q[BYTE_W-2:0], sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_INSN;
         sclk_d  <= 1'b1;
         bit_cnt <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         left_q  <= '0;
         rd_q    <= 1'b0;
         adv_q   <= 1'b0;
         load_q  <= 1'b0;
         addr    <= '0;
         wr_stb  <= 1'b0;
         wr_byte <= '0;
      end else begin
         sclk_d <= sclk_s;
         adv_q  <= 1'b0;
         wr_stb <= 1'b0;
         load_q <= 1'b0;

         if (load_q) tx_q <= rd_byte;

         if (adv_q) begin
            addr <= addr + ADDR_W'(1);
            if (left_q == '0) begin
               phase_q <= PH_INSN;
               rd_q    <= 1'b0;
            end else begin
               left_q <= left_q - LEN_W'(1);
               load_q <= rd_q;
            end
         end

         if (rise) begin
            rx_q    <= full_byte;
            bit_cnt <= bit_cnt + BIT_CW'(1);
            if (last_bit) begin
               if (phase_q == PH_INSN) begin
                  phase_q <= PH_DATA;
                  rd_q    <= full_byte[BYTE_W-1];
                  left_q  <= full_byte[LEN_HI -: LEN_W];
                  addr    <= full_byte[ADDR_W-1:0];
                  load_q  <= full_byte[BYTE_W-1];
               end else begin
                  adv_q <= 1'b1;
                  if (!rd_q) begin
                     wr_stb  <= 1'b1;
                     wr_byte <= full_byte;
                  end
               end
            end
         end

         if (fall && bit_cnt != '0 && phase_q == PH_DATA && rd_q)
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
   end

   assign drive  = (phase_q == PH_DATA) & rd_q;
   assign tx_bit = tx_q[BYTE_W-1];
endmodule

// File: rtl/serial_pause_slave.sv
module serial_pause_slave
   import ssp_pkg::*;
#(
   parameter int LEN_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = BYTE_W - 1 - LEN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              bidir_mode,
   input  logic              sdio_i,
   output logic              sdio_o,
   output logic              sdio_oe,
   output logic              sdo_o,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata
);
   generate
      if (LEN_W < 1 || LEN_W > 4) begin : g_len_chk
         $fatal(1, "LEN_W must lie in 1..4");
      end
      if (ADDR_W != BYTE_W - 1 - LEN_W) begin : g_addr_chk
         $fatal(1, "ADDR_W must fill the instruction byte");
      end
   endgenerate

   logic [1:0] raw_in;
   logic [1:0] syn_out;
   logic       sclk_s;
   logic       cs_act;
   logic       drive;
   logic       tx_bit;
   logic       live;

   assign raw_in = {cs_n, sclk};

   ssp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_out)
   );

   assign sclk_s = syn_out[0];
   assign cs_act = ~syn_out[1];

   ssp_engine #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .cs_act  (cs_act),
      .sdi     (sdio_i),
      .rd_byte (reg_rdata),
      .drive   (drive),
      .tx_bit  (tx_bit),
      .addr    (reg_addr),
      .wr_stb  (reg_we),
      .wr_byte (reg_wdata)
   );

   assign live    = ~cs_n & drive;
   assign sdo_oe  = live & ~bidir_mode;
   assign sdio_oe = live &  bidir_mode;
   assign sdo_o   = sdo_oe  & tx_bit;
   assign sdio_o  = sdio_oe & tx_bit;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              bidir_mode,
   input logic              sdio_oe,
   input logic              sdo_oe,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr
);
   a_r6_hiz_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!sdo_oe && !sdio_oe));

   a_r7_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdo_oe && sdio_oe));

   a_r7_shared_line: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> bidir_mode);

   a_r7_split_line: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !bidir_mode);

   a_r2_one_cycle_we: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_addr == $past(reg_addr) + ADDR_W'(1)));

   a_r8_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (!sdo_oe && !sdio_oe));

   a_r5_no_write_paused: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
      |-> !reg_we);
endmodule

bind serial_pause_slave ssp_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .bidir_mode (bidir_mode),
   .sdio_oe    (sdio_oe),
   .sdo_oe     (sdo_oe),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr)
);

// File: tb/serial_pause_slave_tb.sv
module serial_pause_slave_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b1;
   logic       cs_n = 1'b1;
   logic       bidir_mode = 1'b0;
   logic       sdio_i = 1'b0;
   logic       sdio_o, sdio_oe, sdo_o, sdo_oe, reg_we;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0] mem     [32];
   logic [7:0] exp_mem [32];
   int         checks = 0;
   int         errors = 0;
   int         we_cnt = 0;
   int         cycles = 0;
   logic       last_sdo_oe, last_sdio_oe;

   always #4 clk = ~clk;

   serial_pause_slave u_dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .bidir_mode(bidir_mode),
      .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = mem[reg_addr];

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (reg_we) begin
         mem[reg_addr] = reg_wdata;
         we_cnt = we_cnt + 1;
      end
   end

   // {bidir, instruction, byte3, byte2, byte1, byte0}; byte0 moves first
   localparam logic [40:0] VEC [8] = '{
      {1'b0, 8'h62, 8'h3C, 8'hC3, 8'h55, 8'hAA},
      {1'b0, 8'hE2, 32'h0},
      {1'b1, 8'hE2, 32'h0},
      {1'b0, 8'h3F, 16'h0, 8'h96, 8'h5A},
      {1'b0, 8'hBF, 32'h0},
      {1'b1, 8'h8A, 32'h0},
      {1'b0, 8'h07, 24'h0, 8'h81},
      {1'b1, 8'hC6, 32'h0}
   };

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic sbit(input logic din, output logic dout);
      sclk = 1'b0;
      sdio_i = din;
      repeat (8) @(negedge clk);
      dout = bidir_mode ? sdio_o : sdo_o;
      last_sdo_oe = sdo_oe;
      last_sdio_oe = sdio_oe;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic sbyte(input logic [7:0] d, output logic [7:0] q);
      for (int i = 7; i >= 0; i--) sbit(d[i], q[i]);
   endtask

   task automatic spin_sclk(input int n);
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0; sdio_i = ~sdio_i; repeat (3) @(negedge clk);
         sclk = 1'b1; repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(negedge clk);
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] q, insn, d;
      logic       b;
      int         n, a0, wb;

      for (int i = 0; i < 32; i++) begin
         mem[i] = 8'(i * 29 + 5);
         exp_mem[i] = 8'(i * 29 + 5);
      end
      repeat (4) @(negedge clk);
      // R9: reset state
      chk(sdo_oe == 1'b0, "R9 sdo_oe", 32'(sdo_oe), 0);
      chk(sdio_oe == 1'b0, "R9 sdio_oe", 32'(sdio_oe), 0);
      chk(reg_we == 1'b0, "R9 reg_we", 32'(reg_we), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);

      // R10: every vector runs back to back with cs_n held low
      for (int v = 0; v < 8; v++) begin
         bidir_mode = VEC[v][40];
         insn = VEC[v][39:32];
         n = int'(insn[6:5]) + 1;
         a0 = int'(insn[4:0]);
         sbyte(insn, q);
         chk(!last_sdo_oe && !last_sdio_oe, "R8 quiet instruction", {last_sdo_oe, last_sdio_oe}, 0);
         for (int k = 0; k < n; k++) begin
            if (insn[7]) begin
               sbyte(8'h00, q);
               chk(q == exp_mem[(a0 + k) % 32], "R3 R1 R10 read byte", q, exp_mem[(a0 + k) % 32]);
               chk(last_sdo_oe == !bidir_mode && last_sdio_oe == bidir_mode, "R7 read line select",
                   {last_sdo_oe, last_sdio_oe}, {!bidir_mode, bidir_mode});
            end else begin
               d = VEC[v][8*k +: 8];
               exp_mem[(a0 + k) % 32] = d;
               sbyte(d, q);
               chk(!last_sdo_oe && !last_sdio_oe, "R8 quiet write", {last_sdo_oe, last_sdio_oe}, 0);
            end
         end
         if (!insn[7]) begin
            repeat (4) @(negedge clk);
            for (int k = 0; k < n; k++)
               chk(mem[(a0 + k) % 32] == exp_mem[(a0 + k) % 32], "R2 R1 write landed",
                   mem[(a0 + k) % 32], exp_mem[(a0 + k) % 32]);
         end
      end

      // R5 R6: read paused mid-byte on the shared line
      bidir_mode = 1'b1;
      sbyte(8'h8A, q);
      for (int i = 7; i >= 5; i--) begin sbit(1'b0, b); q[i] = b; end
      chk(sdio_oe == 1'b1, "R7 shared line driven", 32'(sdio_oe), 1);
      cs_n = 1'b1;
      #1;
      chk(!sdio_oe && !sdo_oe, "R6 release at once", {sdo_oe, sdio_oe}, 0);
      repeat (6) @(negedge clk);
      spin_sclk(5);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      for (int i = 4; i >= 0; i--) begin sbit(1'b0, b); q[i] = b; end
      chk(q == exp_mem[10], "R5 resumed read byte", q, exp_mem[10]);

      // R5 R4: write paused at a byte boundary and mid-byte
      bidir_mode = 1'b0;
      wb = we_cnt;
      sbyte(8'h34, q);
      sbyte(8'h11, q);
      cs_n = 1'b1; repeat (6) @(negedge clk);
      spin_sclk(4);
      cs_n = 1'b0; repeat (6) @(negedge clk);
      d = 8'hE7;
      for (int i = 7; i >= 4; i--) sbit(d[i], b);
      cs_n = 1'b1; repeat (6) @(negedge clk);
      spin_sclk(7);
      chk(we_cnt == wb + 1, "R5 no write while paused", we_cnt, wb + 1);
      cs_n = 1'b0; repeat (6) @(negedge clk);
      for (int i = 3; i >= 0; i--) sbit(d[i], b);
      repeat (4) @(negedge clk);
      exp_mem[20] = 8'h11;
      exp_mem[21] = 8'hE7;
      chk(mem[20] == 8'h11, "R5 first byte", mem[20], 8'h11);
      chk(mem[21] == 8'hE7, "R5 split byte", mem[21], 8'hE7);
      chk(we_cnt == wb + 2, "R2 write count", we_cnt, wb + 2);
      sbyte(8'hB4, q);
      sbyte(8'h00, q);
      chk(q == 8'h11, "R4 next instruction read", q, 8'h11);
      sbyte(8'h00, q);
      chk(q == 8'hE7, "R4 second byte", q, 8'hE7);
      sbit(1'b0, b);
      chk(!last_sdo_oe && !last_sdio_oe, "R4 back to instruction", {last_sdo_oe, last_sdio_oe}, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule